// File: doc/BRIEF.md
# Indexed Clock Register Port

This block is the host-facing register front end of a real-time clock. A byte-wide bus with a single address bit reaches a 128-byte register and storage file indirectly: an access to the even address loads a 7-bit index, and an access to the odd address reads or writes the byte that index selects. Indices 0 to 9 hold the time and alarm bytes. Indices 10 to 13 are four control and status registers with their own rules: a mode register, a control register, a flag register and a fixed status register. All higher indices are general storage.

The calendar counter and the periodic divider sit outside this block. They report to it through single-cycle event strobes: periodic tick, alarm match, update start and update end. The block turns these strobes into status flags and drives the interrupt line. It gives the mode and control registers to its neighbours, and it pulses a load strobe when software has changed the time bytes in a way that the calendar must pick up.

Top module: `clkRegPort`

## Requirements
- R1: A write to the even address (busAddr = 0) stores busWdata[6:0] as the index and drops bit 7. A read of the even address returns 0xFF.
- R2: At every index other than 10 to 13, a write to the odd address stores the byte, and a later read of that index returns it.
- R3: Bit 7 of the mode register (index 10, the update-in-progress bit) cannot be written. A write to index 10 stores bits 6:0 and leaves bit 7 at its value.
- R4: Writes to the flag register (index 12) and the status register (index 13) are ignored.
- R5: A read of index 12 returns the current flags. The register is then 0x00, and irqOut is low in the next cycle.
- R6: A write to the control register (index 11) with bit 7 set (set mode) stores the byte with bit 4 forced to 0, and it clears bit 7 of the mode register.
- R7: The flag register has the layout bit 7 = interrupt request, bit 6 = periodic, bit 5 = alarm, bit 4 = update ended. evPeriodic sets bits 6 and 7 only when control bit 6 is set. evAlarm sets bits 5 and 7 only when control bit 5 is set. evUpdEnd always sets bit 4, and sets bit 7 as well when control bit 4 is set.
- R8: evUpdStart sets mode bit 7 unless control bit 7 is set. evUpdEnd clears mode bit 7.
- R9: irqOut is the registered interrupt-request flag. Once high it stays high until index 12 is read or softRst is applied.
- R10: An event strobe in the same cycle as a read of index 12 is kept. The read returns the old flags, and the new flags remain set afterwards.
- R11: softRst clears control bits 6, 5 and 3, clears all flags and lowers irqOut.
- R12: After rstN the mode register is 0x26, the control register 0x02, the flag register 0x00 and the status register 0x80.
- R13: timeLoad pulses for one cycle after either of two writes: a write to index 0 to 9 while control bit 7 is clear, or a write to index 11 that clears control bit 7 while it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| softRst | input | 1 | Synchronous system reset of enables and flags |
| busSel | input | 1 | Bus access this cycle |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = index port, 1 = data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid during a read access |
| evPeriodic | input | 1 | Periodic tick strobe |
| evAlarm | input | 1 | Alarm match strobe |
| evUpdStart | input | 1 | Calendar update begins |
| evUpdEnd | input | 1 | Calendar update finished |
| irqOut | output | 1 | Interrupt request |
| ctrlA | output | 8 | Mode register to the timebase |
| ctrlB | output | 8 | Control register to the calendar |
| timeLoad | output | 1 | Time bytes changed; calendar reloads |

## Verification
The indexed path is tried in three ways: with index bytes that have bit 7 set, with writes to every kind of index (plain storage, mode, control, flag and status), and with read-backs. Together these separate a correct index decode from aliasing, from a lost read-only bit and from a flag or status register that wrongly accepts writes. Each event strobe is applied twice, once with its enable set and once with it clear, which shows whether the interrupt-request bit is gated per source or set by any event. The corner cases are driven directly: an event that collides with a flag read, an update start while set mode is on, and a system reset while an interrupt is pending. They show whether priorities and clearing side effects act in the right order.

// File: rtl/clkRegPkg.sv
package clkRegPkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int TIME_BYTES = 10;

  localparam logic [IDX_W-1:0] IDX_MODE = IDX_W'(10);
  localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(11);
  localparam logic [IDX_W-1:0] IDX_FLAG = IDX_W'(12);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(13);

  localparam logic [DATA_W-1:0] MODE_INIT = 8'h26;
  localparam logic [DATA_W-1:0] CTRL_INIT = 8'h02;
  localparam logic [DATA_W-1:0] STAT_VAL  = 8'h80;
  localparam logic [DATA_W-1:0] SOFT_CLR  = 8'h68;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             wrStore;
    logic             wrMode;
    logic             wrCtrl;
    logic             rdFlag;
  } ctrlStrobes_t;
endpackage

// File: rtl/clkRegCtrl.sv
module clkRegCtrl
  import clkRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              setMode,
  output ctrlStrobes_t      strobes,
  output logic              timeLoad
);
  logic [IDX_W-1:0] idxQ;
  logic dataWr, dataRd, idxWr, special;

  assign idxWr  = busSel && busWe && !busAddr;
  assign dataWr = busSel && busWe && busAddr;
  assign dataRd = busSel && !busWe && busAddr;
  assign special = (idxQ == IDX_MODE) || (idxQ == IDX_CTRL) ||
                   (idxQ == IDX_FLAG) || (idxQ == IDX_STAT);

  // R1: only the low bits of the data byte form the index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      idxQ <= '0;
    else if (idxWr) idxQ <= busWdata[IDX_W-1:0];
  end

  always_comb begin
    strobes.idx     = idxQ;
    strobes.wrStore = dataWr && !special;
    strobes.wrMode  = dataWr && (idxQ == IDX_MODE);
    strobes.wrCtrl  = dataWr && (idxQ == IDX_CTRL);
    strobes.rdFlag  = dataRd && (idxQ == IDX_FLAG);
  end

  // R13: reload request for the calendar
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeLoad <= 1'b0;
    else timeLoad <= (dataWr && (idxQ < IDX_W'(TIME_BYTES)) && !setMode) ||
                     (dataWr && (idxQ == IDX_CTRL) && !busWdata[DATA_W-1] && setMode);
  end

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idxWr |=> idxQ == $past(idxQ));
endmodule

// File: rtl/clkRegData.sv
module clkRegData
  import clkRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  ctrlStrobes_t      strobes,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              evPeriodic,
  input  logic              evAlarm,
  input  logic              evUpdStart,
  input  logic              evUpdEnd,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] regMode,
  output logic [DATA_W-1:0] regCtrl,
  output logic              irqOut
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] regFlag;
  logic [DATA_W-1:0] modeNext, ctrlNext, flagNext, flagSet;

  always_ff @(posedge clk) begin
    if (strobes.wrStore) store[strobes.idx] <= busWdata;
  end

  // R3, R8, R6: update-in-progress bit handling
  always_comb begin
    modeNext = regMode;
    if (strobes.wrMode) modeNext[DATA_W-2:0] = busWdata[DATA_W-2:0];
    if (evUpdStart && !regCtrl[7]) modeNext[7] = 1'b1;
    if (evUpdEnd) modeNext[7] = 1'b0;
    if (strobes.wrCtrl && busWdata[7]) modeNext[7] = 1'b0;
  end

  // R6, R11
  always_comb begin
    ctrlNext = regCtrl;
    if (strobes.wrCtrl) ctrlNext = busWdata[7] ? (busWdata & 8'hEF) : busWdata;
    if (softRst) ctrlNext = regCtrl & ~SOFT_CLR;
  end

  // R7, R10: set bits win over the clear-on-read
  always_comb begin
    flagSet = '0;
    if (evPeriodic && regCtrl[6]) flagSet = flagSet | 8'hC0;
    if (evAlarm && regCtrl[5])    flagSet = flagSet | 8'hA0;
    if (evUpdEnd)                 flagSet = flagSet | (regCtrl[4] ? 8'h90 : 8'h10);
    flagNext = (strobes.rdFlag ? '0 : regFlag) | flagSet;
    if (softRst) flagNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regMode <= MODE_INIT;
      regCtrl <= CTRL_INIT;
      regFlag <= '0;
    end else begin
      regMode <= modeNext;
      regCtrl <= ctrlNext;
      regFlag <= flagNext;
    end
  end

  // R9: interrupt is the registered request flag
  assign irqOut = regFlag[7];

  always_comb begin
    if (!busAddr) busRdata = '1;
    else begin
      case (strobes.idx)
        IDX_MODE: busRdata = regMode;
        IDX_CTRL: busRdata = regCtrl;
        IDX_FLAG: busRdata = regFlag;
        IDX_STAT: busRdata = STAT_VAL;
        default:  busRdata = store[strobes.idx];
      endcase
    end
  end

  // R3
  uip_readonly_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrMode && !evUpdStart && !evUpdEnd) |=> regMode[7] == $past(regMode[7]));
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdFlag && !evPeriodic && !evAlarm && !evUpdEnd) |=> (regFlag == '0) && !irqOut);
  // R6
  set_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrCtrl && busWdata[7] && !softRst) |=> !regCtrl[4] && !regMode[7]);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strobes.rdFlag && !softRst) |=> irqOut);
  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (regFlag == '0) && ((regCtrl & SOFT_CLR) == '0));
  // R8
  uip_set_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regCtrl[7] && !regMode[7]) |=> !regMode[7]);
endmodule

// File: rtl/clkRegPort.sv
module clkRegPort
  import clkRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softRst,
  input  logic              busSel,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              evPeriodic,
  input  logic              evAlarm,
  input  logic              evUpdStart,
  input  logic              evUpdEnd,
  output logic              irqOut,
  output logic [DATA_W-1:0] ctrlA,
  output logic [DATA_W-1:0] ctrlB,
  output logic              timeLoad
);
  ctrlStrobes_t strobes;

  clkRegCtrl uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .setMode(ctrlB[7]), .strobes(strobes), .timeLoad(timeLoad)
  );

  clkRegData uData (
    .clk(clk), .rstN(rstN), .softRst(softRst), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .evPeriodic(evPeriodic), .evAlarm(evAlarm),
    .evUpdStart(evUpdStart), .evUpdEnd(evUpdEnd), .busRdata(busRdata),
    .regMode(ctrlA), .regCtrl(ctrlB), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_clkRegPort.sv
module tb_clkRegPort;
  logic clk = 1'b0, rstN = 1'b0, softRst = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0, busAddr = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic evPeriodic = 1'b0, evAlarm = 1'b0, evUpdStart = 1'b0, evUpdEnd = 1'b0;
  logic irqOut, timeLoad;
  logic [7:0] ctrlA, ctrlB;
  int compared = 0, mismatched = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  clkRegPort dut (.*);

  // entry: {addr, we, data, expected read}
  localparam int NV = 27;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0,1'b1,8'h8A,8'h00}, {1'b1,1'b0,8'h00,8'h26}, {1'b1,1'b1,8'hFF,8'h00},
    {1'b1,1'b0,8'h00,8'h7F}, {1'b1,1'b1,8'h26,8'h00}, {1'b0,1'b0,8'h00,8'hFF},
    {1'b0,1'b1,8'h0D,8'h00}, {1'b1,1'b1,8'h00,8'h00}, {1'b1,1'b0,8'h00,8'h80},
    {1'b0,1'b1,8'h0C,8'h00}, {1'b1,1'b1,8'hF0,8'h00}, {1'b1,1'b0,8'h00,8'h00},
    {1'b0,1'b1,8'h05,8'h00}, {1'b1,1'b1,8'h12,8'h00}, {1'b0,1'b1,8'h45,8'h00},
    {1'b1,1'b1,8'hAB,8'h00}, {1'b0,1'b1,8'h05,8'h00}, {1'b1,1'b0,8'h00,8'h12},
    {1'b0,1'b1,8'h45,8'h00}, {1'b1,1'b0,8'h00,8'hAB}, {1'b0,1'b1,8'h7F,8'h00},
    {1'b1,1'b1,8'h5A,8'h00}, {1'b1,1'b0,8'h00,8'h5A}, {1'b0,1'b1,8'h0B,8'h00},
    {1'b1,1'b1,8'h92,8'h00}, {1'b1,1'b0,8'h00,8'h82}, {1'b1,1'b1,8'h02,8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic a, input logic w, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    busSel = 1'b1; busAddr = a; busWe = w; busWdata = d;
    #5 r = busRdata;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    logic [7:0] dummy;
    busOp(a, 1'b1, d, dummy);
  endtask

  task automatic rdIdx(input logic [7:0] idx, output logic [7:0] r);
    wr(1'b0, idx);
    busOp(1'b1, 1'b0, 8'h00, r);
  endtask

  // strobe bits: {periodic, alarm, updStart, updEnd, softRst}
  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    {evPeriodic, evAlarm, evUpdStart, evUpdEnd, softRst} = ev;
    @(negedge clk);
    {evPeriodic, evAlarm, evUpdStart, evUpdEnd, softRst} = '0;
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 power-up values
    chk("R12 mode", ctrlA, 8'h26);
    chk("R12 ctrl", ctrlB, 8'h02);
    chk("R12 irq", {7'b0, irqOut}, 8'h00);

    // Table walk: R1 index masking and even read, R3, R4, R12 status, R2 storage, R6
    for (int i = 0; i < NV; i++) begin
      busOp(VEC[i][17], VEC[i][16], VEC[i][15:8], rd);
      if (!VEC[i][16]) chk($sformatf("R1-table vec %0d", i), rd, VEC[i][7:0]);
    end
    chk("R6 ctrl after clear", ctrlB, 8'h02);

    // R8 update start sets UIP, R3 write keeps it
    pulse(5'b00100);
    chk("R8 uip set", {7'b0, ctrlA[7]}, 8'h01);
    wr(1'b0, 8'h0A); wr(1'b1, 8'h00);
    busOp(1'b1, 1'b0, 8'h00, rd);
    chk("R3 uip kept", rd, 8'h80);
    // R8 update end clears UIP, R7 update flag without enable
    pulse(5'b00010);
    chk("R8 uip clear", ctrlA, 8'h00);
    chk("R7 no irq", {7'b0, irqOut}, 8'h00);
    rdIdx(8'h0C, rd);
    chk("R5 flag read", rd, 8'h10);
    busOp(1'b1, 1'b0, 8'h00, rd);
    chk("R5 flag cleared", rd, 8'h00);

    // R7 periodic with enable, R9 irq holds
    wr(1'b0, 8'h0B); wr(1'b1, 8'h42);
    pulse(5'b10000);
    chk("R9 irq up", {7'b0, irqOut}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R9 irq held", {7'b0, irqOut}, 8'h01);
    rdIdx(8'h0C, rd);
    chk("R7 periodic flags", rd, 8'hC0);
    chk("R5 irq dropped", {7'b0, irqOut}, 8'h00);

    // R7 periodic ignored when disabled
    wr(1'b0, 8'h0B); wr(1'b1, 8'h02);
    pulse(5'b10000);
    rdIdx(8'h0C, rd);
    chk("R7 periodic gated", rd, 8'h00);
    // R7 alarm
    wr(1'b0, 8'h0B); wr(1'b1, 8'h22);
    pulse(5'b01000);
    rdIdx(8'h0C, rd);
    chk("R7 alarm flags", rd, 8'hA0);
    // R7 update end with enable
    wr(1'b0, 8'h0B); wr(1'b1, 8'h12);
    pulse(5'b00010);
    rdIdx(8'h0C, rd);
    chk("R7 update flags", rd, 8'h90);

    // R10 event in same cycle as flag read
    wr(1'b0, 8'h0B); wr(1'b1, 8'h42);
    wr(1'b0, 8'h0C);
    @(negedge clk);
    busSel = 1'b1; busAddr = 1'b1; busWe = 1'b0; evPeriodic = 1'b1;
    #5 rd = busRdata;
    @(negedge clk);
    busSel = 1'b0; evPeriodic = 1'b0;
    chk("R10 old value", rd, 8'h00);
    chk("R10 irq kept", {7'b0, irqOut}, 8'h01);
    busOp(1'b1, 1'b0, 8'h00, rd);
    chk("R10 flags kept", rd, 8'hC0);

    // R6 set-mode write clears UIP; R8 no UIP in set mode; R13 load strobes
    wr(1'b0, 8'h0B); wr(1'b1, 8'h02);
    pulse(5'b00100);
    wr(1'b1, 8'h92);
    chk("R6 uip cleared", {7'b0, ctrlA[7]}, 8'h00);
    chk("R6 ctrl stored", ctrlB, 8'h82);
    pulse(5'b00100);
    chk("R8 uip blocked", {7'b0, ctrlA[7]}, 8'h00);
    pulse(5'b00010);
    wr(1'b0, 8'h03); wr(1'b1, 8'h11);
    chk("R13 no load in set mode", {7'b0, timeLoad}, 8'h00);
    wr(1'b0, 8'h0B); wr(1'b1, 8'h02);
    chk("R13 load on leave", {7'b0, timeLoad}, 8'h01);
    @(negedge clk);
    chk("R13 single pulse", {7'b0, timeLoad}, 8'h00);
    wr(1'b0, 8'h03); wr(1'b1, 8'h22);
    chk("R13 load on time write", {7'b0, timeLoad}, 8'h01);

    // R11 system reset
    wr(1'b0, 8'h0B); wr(1'b1, 8'h6A);
    pulse(5'b10000);
    chk("R11 irq before", {7'b0, irqOut}, 8'h01);
    pulse(5'b00001);
    chk("R11 ctrl", ctrlB, 8'h02);
    chk("R11 irq", {7'b0, irqOut}, 8'h00);
    rdIdx(8'h0C, rd);
    chk("R11 flags", rd, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule